// File: doc/BRIEF.md
# Word Memory Bus Completer

This block is a completer on the simple two-phase APB peripheral bus that carries its own storage: 1024 words of 32 bits, covering a 4 KB window at the bottom of the address space. A requester opens each transfer with a setup phase and then completes it with an access phase. On a write, the word is stored when the access phase completes. On a read, the stored word is presented on the read-data output during the access phase.

Each word has a written flag. The flag is set by any write and cleared by reset. A word whose flag is clear reads as zero, so locations that were never written, or that were wiped by reset, return zero with no need to clear the storage array itself. The active-low reset is asynchronous and clears every flag and the read-data register in the same moment.

The completer is always ready. It never stalls the requester, so no ready or error pin exists and no back-pressure can occur. Transfers may follow one another with no idle cycle in between, and a read placed directly after a write to the same word returns the new data.

Top module: `apb_wordmem_slave`

## Requirements
- R1: A transfer starts only on a rising edge where psel=1 and penable=0 (setup). pwrite at that edge selects write (1) or read (0). A psel=1, penable=1 cycle with no setup before it stores nothing.
- R2: A write stores pwdata at the word addressed by paddr, both sampled on the rising edge that ends the access phase (psel=1, penable=1).
- R3: A read of a word that has not been written since the last reset returns 0.
- R4: A read returns the most recent data written to that word, including a read whose setup directly follows the write's access phase.
- R5: While rst_n is 0, prdata is 0. After reset, every word reads as 0, including a word whose write was in its access phase when reset arrived.
- R6: paddr bits 11:2 select one of 1024 words. Bits 1:0 are ignored, so 0x00B reads the same word as 0x008.
- R7: A write with any of paddr bits 31:12 set changes no word, including the word its bits 11:2 name. A read with any of those bits set returns 0.
- R8: prdata is loaded on the setup edge of a read, is valid through that read's access phase, and holds its value through writes and idle cycles until the next read setup.
- R9: Back-to-back transfers, where a setup phase follows an access phase directly, are accepted for any mix of reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| paddr | input | 32 | Byte address of the transfer |
| pwrite | input | 1 | 1 for a write, 0 for a read, sampled at setup |
| psel | input | 1 | Completer selected |
| penable | input | 1 | 0 in the setup phase, 1 in the access phase |
| pwdata | input | 32 | Write data, taken at the end of the access phase |
| prdata | output | 32 | Read data, valid in the access phase of a read |

## Verification
Two functions share a cycle in two places. A write's commit and a following read's lookup fall on consecutive edges, and the reset clear can land on the same edge as a write commit. The first case is provoked by table rows that start a read setup right after a write's access phase to the same word; the read must return the new word. The second case is provoked by pulling rst_n low in the middle of a write's access phase; every word read afterwards, the target word included, must return zero.

// File: rtl/apb_wm_pkg.sv
`timescale 1ns/1ps
package apb_wm_pkg;
  // Bus phase as seen by the completer
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACCESS = 1'b1
  } wm_phase_t;

  // Bytes per word as a log2, from the data width
  function automatic int lane_bits(input int data_w);
    return $clog2(data_w / 8);
  endfunction
endpackage

// File: rtl/apb_wm_phase.sv
`timescale 1ns/1ps
// Tracks setup/access phases, produces write-commit and read-start strobes
module apb_wm_phase
  import apb_wm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12,
  parameter int LANE_W   = 2,
  localparam int IDX_W   = WIN_BITS - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              rd_start,
  output logic              wr_commit,
  output logic              in_window,
  output logic [IDX_W-1:0]  word_idx
);
  wm_phase_t phase_q;
  logic      pend_wr_q;
  logic      setup_seen;
  logic [LANE_W-1:0] unused_lane;

  assign setup_seen  = psel && !penable;
  assign in_window   = (paddr[ADDR_W-1:WIN_BITS] == '0);
  assign word_idx    = paddr[WIN_BITS-1:LANE_W];
  assign unused_lane = paddr[LANE_W-1:0];

  // A phase only opens on a setup edge; any other edge returns to idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      pend_wr_q <= 1'b0;
    end else begin
      phase_q <= setup_seen ? PH_ACCESS : PH_IDLE;
      if (setup_seen) pend_wr_q <= pwrite;
    end
  end

  assign rd_start  = setup_seen && !pwrite;
  assign wr_commit = (phase_q == PH_ACCESS) && psel && penable
                     && pend_wr_q && in_window;
endmodule

// File: rtl/apb_wm_store.sv
`timescale 1ns/1ps
// Word array plus per-word written flags; flags clear asynchronously
module apb_wm_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_written,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  written_q;

  // Storage needs no reset: the flags decide what a read sees
  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     written_q         <= '0;
    else if (wr_en) written_q[wr_idx] <= 1'b1;
  end

  assign rd_written = written_q[rd_idx];
  assign rd_word    = words[rd_idx];
endmodule

// File: rtl/apb_wm_rdata.sv
`timescale 1ns/1ps
// Read-data register: loads at a read setup, holds otherwise
module apb_wm_rdata #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              hit,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] prdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prdata <= '0;
    else if (load) prdata <= hit ? word : '0;
  end
endmodule

// File: rtl/apb_wordmem_slave.sv
`timescale 1ns/1ps
module apb_wordmem_slave
  import apb_wm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic              psel,
  input  logic              penable,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);
  localparam int LANE_W = lane_bits(DATA_W);
  localparam int IDX_W  = WIN_BITS - LANE_W;

  logic             rd_start;
  logic             wr_commit;
  logic             in_window;
  logic [IDX_W-1:0] word_idx;
  logic             rd_written;
  logic [DATA_W-1:0] rd_word;

  apb_wm_phase #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .LANE_W(LANE_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .rd_start(rd_start),
    .wr_commit(wr_commit), .in_window(in_window), .word_idx(word_idx)
  );

  apb_wm_store #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_idx(word_idx),
    .wr_data(pwdata), .rd_idx(word_idx), .rd_written(rd_written),
    .rd_word(rd_word)
  );

  apb_wm_rdata #(
    .DATA_W(DATA_W)
  ) u_rdata (
    .clk(clk), .rst_n(rst_n), .load(rd_start),
    .hit(rd_written && in_window), .word(rd_word), .prdata(prdata)
  );
endmodule

// File: rtl/apb_wordmem_slave_chk.sv
`timescale 1ns/1ps
module apb_wordmem_slave_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] paddr,
  input logic              pwrite,
  input logic              psel,
  input logic              penable,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata
);
  // R5: read data is zero whenever reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r5_reset_zero: assert (prdata == '0)
        else $error("prdata nonzero in reset");
    end
  end

  // R8: outside a read setup, prdata keeps its value
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && !penable && !pwrite) |=> $stable(prdata));

  // R7: a read outside the window returns zero
  a_r7_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && !pwrite && paddr[ADDR_W-1:WIN_BITS] != '0)
    |=> prdata == '0);

  // R4: read setup right after an in-window write access to the same word
  a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && !pwrite && paddr[ADDR_W-1:WIN_BITS] == '0
     && $past(psel && penable && pwrite)
     && $past(paddr[ADDR_W-1:WIN_BITS]) == '0
     && $past(paddr[WIN_BITS-1:2]) == paddr[WIN_BITS-1:2])
    |=> prdata == $past(pwdata, 2));
endmodule

bind apb_wordmem_slave apb_wordmem_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .paddr(paddr), .pwrite(pwrite), .psel(psel),
  .penable(penable), .pwdata(pwdata), .prdata(prdata)
);

// File: tb/apb_wordmem_slave_tb.sv
`timescale 1ns/1ps
module apb_wordmem_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] paddr = '0;
  logic        pwrite = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  apb_wordmem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .paddr(paddr), .pwrite(pwrite), .psel(psel),
    .penable(penable), .pwdata(pwdata), .prdata(prdata)
  );

  typedef struct packed {
    logic        wr;
    logic        b2b;
    logic [31:0] addr;
    logic [31:0] data;  // write data, or expected read data
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000}, // 0  R3 unwritten
    '{1'b1, 1'b0, 32'h0000_0004, 32'hA5A5_0004}, // 1  R2 write
    '{1'b0, 1'b1, 32'h0000_0004, 32'hA5A5_0004}, // 2  R4 R9 read right after write
    '{1'b1, 1'b0, 32'h0000_0008, 32'h1111_2222}, // 3  R2
    '{1'b1, 1'b1, 32'h0000_0008, 32'hC0DE_0008}, // 4  R9 overwrite
    '{1'b0, 1'b1, 32'h0000_0008, 32'hC0DE_0008}, // 5  R4 latest value
    '{1'b1, 1'b0, 32'h0000_0FFC, 32'hDEAD_BEEF}, // 6  R6 top word
    '{1'b0, 1'b0, 32'h0000_0FFC, 32'hDEAD_BEEF}, // 7  R6
    '{1'b0, 1'b0, 32'h0000_000B, 32'hC0DE_0008}, // 8  R6 low bits ignored
    '{1'b1, 1'b0, 32'h0000_1004, 32'hEEEE_1004}, // 9  R7 outside write
    '{1'b0, 1'b1, 32'h0000_0004, 32'hA5A5_0004}, // 10 R7 alias untouched
    '{1'b0, 1'b0, 32'h0000_1004, 32'h0000_0000}, // 11 R7 outside read
    '{1'b0, 1'b0, 32'h0000_000C, 32'h0000_0000}  // 12 R3
  };

  function automatic string req_of(input int i);
    case (i)
      0, 12:    return "R3";
      2, 5:     return "R4";
      7, 8:     return "R6";
      10, 11:   return "R7";
      default:  return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: prdata actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // One transfer; leaves the bus in the access phase. Returns prdata sampled
  // in the access phase (loaded at the setup edge).
  task automatic xfer(input logic wr, input logic b2b, input logic [31:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
    if (!b2b) idle();
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
    pwdata = wr ? d : 32'h0;
    @(negedge clk);
    penable = 1'b1;
    #1 rd = prdata;
  endtask

  task automatic read_chk(input string req, input logic [31:0] a,
                          input logic [31:0] exp);
    logic [31:0] got;
    xfer(1'b0, 1'b0, a, 32'h0, got);
    check(req, got, exp);
  endtask

  task automatic run_all();
    logic [31:0] got;
    // Reset state, R5
    repeat (2) @(negedge clk);
    check("R5", prdata, 32'h0);
    rst_n = 1'b1;
    // Vector table, R1 R2 R3 R4 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].b2b, VECS[i].addr, VECS[i].data, got);
      if (!VECS[i].wr) check(req_of(i), got, VECS[i].data);
    end
    // R8: a write and idles leave prdata at the last read value
    read_chk("R8", 32'h0000_0008, 32'hC0DE_0008);
    xfer(1'b1, 1'b1, 32'h0000_0008, 32'h0F0F_0F0F, got);
    repeat (3) idle();
    check("R8", prdata, 32'hC0DE_0008);
    read_chk("R8", 32'h0000_0008, 32'h0F0F_0F0F);
    // R1: an access phase with no setup before it stores nothing
    repeat (2) idle();
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1;
    paddr = 32'h0000_0020; pwdata = 32'h1234_5678;
    read_chk("R1", 32'h0000_0020, 32'h0);
    // R5: reset in the middle of a write access phase
    idle();
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
    paddr = 32'h0000_0030; pwdata = 32'hFACE_0030;
    @(negedge clk);
    penable = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R5", prdata, 32'h0);
    psel = 1'b0; penable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk("R5", 32'h0000_0030, 32'h0);
    read_chk("R5", 32'h0000_0004, 32'h0);
    read_chk("R5", 32'h0000_0FFC, 32'h0);
    idle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule